// File: doc/BRIEF.md
# Shared-Timebase Capture/Compare Array

The block is a bank of five capture/compare channels that all watch one 16-bit up-counter. The counter advances on one of four tick sources: the system clock divided by six, the system clock divided by two, a one-cycle pulse from an external timer, or rising edges on an external count pin. Each channel owns a 16-bit value register, one input pin and one output pin. A channel can be switched off, or set to one of these modes:
- capture the counter on rising, falling or both edges of its input pin;
- raise a flag when the counter reaches its value;
- toggle its output pin on that match;
- drive an 8-bit pulse-width waveform.

Only the last channel also has a watchdog mode, in which a match requests a system reset.

Software sees the block through a byte-wide register port. Writes take effect at the clock edge. Reads are combinational from the address.

The counter has two states. In CNT_HALT it holds its value. A control write with the run bit set moves it to CNT_RUN (transition `start`). In CNT_RUN it steps once per selected tick, and a control write with the run bit clear moves it back to CNT_HALT (transition `stop`).

Each channel's mode register is its state register. The states are U_OFF, U_CAP_RISE, U_CAP_FALL, U_CAP_BOTH, U_TIMER, U_TOGGLE, U_PWM and U_WATCH. The only transition is `reconfigure`: a write to the channel's mode address moves it to the written state. On a channel that is not the last one, U_WATCH behaves as U_OFF.

Top module: `pca_array`

## Requirements
- R1: After reset the following are all zero: every register (control, counter, flags, modes, values), every output pin, the overflow flag and the reset request.
- R2: Register map:
  - 0x00 control: bit0 run, bits2:1 source, bit3 overflow flag.
  - 0x01 counter low byte; 0x02 counter high byte. Writing either byte loads that byte.
  - 0x03 channel flags, with bit i belonging to channel i.
  - 0x08+i mode of channel i, in bits2:0.
  - 0x10+2i low byte and 0x11+2i high byte of channel i's value.

  The counter steps by exactly one per selected tick while run is 1, and holds while run is 0.
- R3: Source codes: 0 selects the clock divided by 6, 1 the clock divided by 2, 2 the external overflow pulse (taken as is), and 3 the external count pin. The pin is synchronised through two flip-flops and counted on its rising edge.
- R4: When the counter steps from 0xFFFF to 0x0000, control bit3 is set. It stays set until software writes 0 to that bit.
- R5: Mode codes 1, 2 and 3 capture the counter into the channel value on a rising, falling or either edge of the synchronised input pin, and set the channel flag. Edges the mode does not select change nothing.
- R6: Mode 4 sets the channel flag on the edge at which the counter steps onto the channel value, and at no other step.
- R7: Mode 5 toggles the channel output pin on each match, and leaves it unchanged on steps that do not match.
- R8: In mode 6 the output pin is 0 while the counter low byte is below a duty byte, and 1 otherwise. The duty byte is reloaded from the value high byte only when the counter low byte wraps from 0xFF to 0x00, so a new duty waits for the next wrap.
- R9: Mode 7 on the last channel is a watchdog. A match gives a one-cycle reset request and sets that channel's flag, and writing the value before the match moves the match away. On any other channel, mode 7 does nothing.
- R10: Writing the flags register clears each flag whose data bit is 0 and keeps each flag whose bit is 1. A flag event in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| ovf_tick | input | 1 | One-cycle overflow pulse from an external timer |
| ext_cnt_pin | input | 1 | External count pin (asynchronous) |
| unit_pin_in | input | 5 | Channel input pins (asynchronous) |
| unit_pin_out | output | 5 | Channel output pins |
| unit_flag | output | 5 | Channel event flags |
| ovf_flag | output | 1 | Counter overflow flag |
| wdog_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
Two functions meet in a single cycle when a channel's match and a software write to the flags register land on the same edge. The bench provokes this by loading the counter one below the compare value, then raising the overflow tick on the very cycle it writes zero to the flags. It then expects the flag to read back as set. A second collision is a low-byte wrap arriving after a duty write in pulse-width mode; there the bench sweeps every low-byte value and checks that the old duty holds until the wrap edge.

// File: rtl/pca_pkg.sv
package pca_pkg;

    typedef enum logic [2:0] {
        U_OFF      = 3'd0,
        U_CAP_RISE = 3'd1,
        U_CAP_FALL = 3'd2,
        U_CAP_BOTH = 3'd3,
        U_TIMER    = 3'd4,
        U_TOGGLE   = 3'd5,
        U_PWM      = 3'd6,
        U_WATCH    = 3'd7
    } unit_mode_e;

    typedef enum logic [1:0] {
        SRC_DIV_SLOW = 2'd0,
        SRC_DIV_FAST = 2'd1,
        SRC_OVF      = 2'd2,
        SRC_PIN      = 2'd3
    } src_sel_e;

    typedef enum logic {
        CNT_HALT = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/pca_tick_gen.sv
module pca_tick_gen
    import pca_pkg::*;
#(
    parameter int DIV_SLOW    = 6,
    parameter int DIV_FAST    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  src_sel_e sel,
    input  logic     ovf_pulse,
    input  logic     ext_pin,
    output logic     tick
);
    localparam int SLOW_W = $clog2(DIV_SLOW);
    localparam int FAST_W = $clog2(DIV_FAST);

    logic [SLOW_W-1:0]    slow_q;
    logic [FAST_W-1:0]    fast_q;
    logic [SYNC_STAGES:0] pin_sh;
    logic slow_tick, fast_tick, pin_rise;

    assign slow_tick = (slow_q == SLOW_W'(DIV_SLOW - 1));
    assign fast_tick = (fast_q == FAST_W'(DIV_FAST - 1));
    assign pin_rise  = pin_sh[SYNC_STAGES-1] & ~pin_sh[SYNC_STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slow_q <= '0;
            fast_q <= '0;
            pin_sh <= '0;
        end else begin
            slow_q <= slow_tick ? '0 : slow_q + SLOW_W'(1);
            fast_q <= fast_tick ? '0 : fast_q + FAST_W'(1);
            pin_sh <= {pin_sh[SYNC_STAGES-1:0], ext_pin};
        end
    end

    always_comb begin
        unique case (sel)
            SRC_DIV_SLOW: tick = slow_tick;
            SRC_DIV_FAST: tick = fast_tick;
            SRC_OVF:      tick = ovf_pulse;
            SRC_PIN:      tick = pin_rise;
        endcase
    end
endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
    import pca_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run_wr,
    input  logic              run_val,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output cnt_state_e        state,
    output logic [CNT_W-1:0]  cnt,
    output logic              step,
    output logic              lo_wrap,
    output logic              full_wrap
);
    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_HALT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_HALT: if (run_wr && run_val)  state_d = CNT_RUN;
            CNT_RUN:  if (run_wr && !run_val) state_d = CNT_HALT;
        endcase
    end

    // outputs of the state
    always_comb begin
        unique case (state_q)
            CNT_HALT: step = 1'b0;
            CNT_RUN:  step = tick;
        endcase
    end

    assign lo_wrap   = step && (cnt_q[DATA_W-1:0] == '1);
    assign full_wrap = step && (cnt_q == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt_q[DATA_W-1:0]     <= wdata;
            if (wr_hi) cnt_q[CNT_W-1:DATA_W] <= wdata;
        end else if (step) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign state = state_q;
    assign cnt   = cnt_q;
endmodule

// File: rtl/pca_unit.sv
module pca_unit
    import pca_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit WATCH_OK    = 1'b0,
    localparam int CNT_W      = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              step,
    input  logic              lo_wrap,
    input  logic              pin_in,
    output unit_mode_e        mode,
    output logic [CNT_W-1:0]  val,
    output logic              hit,
    output logic              pin_out,
    output logic              wd_req
);
    unit_mode_e           mode_q, eff_st;
    logic [CNT_W-1:0]     val_q, cnt_nx;
    logic [DATA_W-1:0]    duty_q;
    logic [SYNC_STAGES:0] pin_sh;
    logic tog_q, wd_q;
    logic rise, fall, match, cap_evt, hit_c, pin_c, tog_evt, wd_evt;

    assign rise   = pin_sh[SYNC_STAGES-1] & ~pin_sh[SYNC_STAGES];
    assign fall   = ~pin_sh[SYNC_STAGES-1] & pin_sh[SYNC_STAGES];
    assign cnt_nx = cnt + CNT_W'(1);
    assign match  = step && (cnt_nx == val_q);

    // state register: the mode, changed only by a reconfigure write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= U_OFF;
        else if (wr_mode) mode_q <= unit_mode_e'(wdata[2:0]);
    end

    assign eff_st = (mode_q == U_WATCH && !WATCH_OK) ? U_OFF : mode_q;

    // outputs of the state
    always_comb begin
        cap_evt = 1'b0;
        hit_c   = 1'b0;
        pin_c   = 1'b0;
        tog_evt = 1'b0;
        wd_evt  = 1'b0;
        unique case (eff_st)
            U_OFF:      ;
            U_CAP_RISE: begin cap_evt = rise;        hit_c = rise;        end
            U_CAP_FALL: begin cap_evt = fall;        hit_c = fall;        end
            U_CAP_BOTH: begin cap_evt = rise | fall; hit_c = rise | fall; end
            U_TIMER:    hit_c = match;
            U_TOGGLE:   begin hit_c = match; tog_evt = match; pin_c = tog_q; end
            U_PWM:      pin_c = (cnt[DATA_W-1:0] >= duty_q);
            U_WATCH:    begin hit_c = match; wd_evt = match; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q  <= '0;
            duty_q <= '0;
            pin_sh <= '0;
            tog_q  <= 1'b0;
            wd_q   <= 1'b0;
        end else begin
            pin_sh <= {pin_sh[SYNC_STAGES-1:0], pin_in};
            if (wr_lo || wr_hi) begin
                if (wr_lo) val_q[DATA_W-1:0]     <= wdata;
                if (wr_hi) val_q[CNT_W-1:DATA_W] <= wdata;
            end else if (cap_evt) begin
                val_q <= cnt;
            end
            if (lo_wrap) duty_q <= val_q[CNT_W-1:DATA_W];
            if (tog_evt) tog_q  <= ~tog_q;
            wd_q <= wd_evt;
        end
    end

    assign mode    = mode_q;
    assign val     = val_q;
    assign hit     = hit_c;
    assign pin_out = pin_c;
    assign wd_req  = wd_q;
endmodule

// File: rtl/pca_array.sv
module pca_array
    import pca_pkg::*;
#(
    parameter int N_UNITS     = 5,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 5,
    parameter int DIV_SLOW    = 6,
    parameter int DIV_FAST    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               ovf_tick,
    input  logic               ext_cnt_pin,
    input  logic [N_UNITS-1:0] unit_pin_in,
    output logic [N_UNITS-1:0] unit_pin_out,
    output logic [N_UNITS-1:0] unit_flag,
    output logic               ovf_flag,
    output logic               wdog_rst_req
);
    localparam int CNT_W     = 2 * DATA_W;
    localparam int A_CTRL    = 0;
    localparam int A_CNT_LO  = 1;
    localparam int A_CNT_HI  = 2;
    localparam int A_FLAGS   = 3;
    localparam int MODE_BASE = 8;
    localparam int VAL_BASE  = 16;
    localparam int OVF_BIT   = 3;

    logic wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_flags;
    src_sel_e           src_q;
    logic               ovf_q, tick, step, lo_wrap, full_wrap;
    cnt_state_e         cnt_state;
    logic [CNT_W-1:0]   cnt_q;
    logic [N_UNITS-1:0] flags_q, hits, wd_v;
    unit_mode_e         unit_mode [N_UNITS];
    logic [CNT_W-1:0]   unit_val  [N_UNITS];

    assign wr_ctrl   = wr_en && (addr == ADDR_W'(A_CTRL));
    assign wr_cnt_lo = wr_en && (addr == ADDR_W'(A_CNT_LO));
    assign wr_cnt_hi = wr_en && (addr == ADDR_W'(A_CNT_HI));
    assign wr_flags  = wr_en && (addr == ADDR_W'(A_FLAGS));

    pca_tick_gen #(
        .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .SYNC_STAGES(SYNC_STAGES)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .sel(src_q), .ovf_pulse(ovf_tick),
        .ext_pin(ext_cnt_pin), .tick(tick)
    );

    pca_timebase #(.DATA_W(DATA_W)) u_base (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run_wr(wr_ctrl),
        .run_val(wdata[0]), .wr_lo(wr_cnt_lo), .wr_hi(wr_cnt_hi),
        .wdata(wdata), .state(cnt_state), .cnt(cnt_q), .step(step),
        .lo_wrap(lo_wrap), .full_wrap(full_wrap)
    );

    for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
        logic wr_m, wr_l, wr_h;
        assign wr_m = wr_en && (addr == ADDR_W'(MODE_BASE + i));
        assign wr_l = wr_en && (addr == ADDR_W'(VAL_BASE + 2 * i));
        assign wr_h = wr_en && (addr == ADDR_W'(VAL_BASE + 2 * i + 1));

        pca_unit #(
            .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES),
            .WATCH_OK(i == N_UNITS - 1)
        ) u_unit (
            .clk(clk), .rst_n(rst_n), .wr_mode(wr_m), .wr_lo(wr_l),
            .wr_hi(wr_h), .wdata(wdata), .cnt(cnt_q), .step(step),
            .lo_wrap(lo_wrap), .pin_in(unit_pin_in[i]), .mode(unit_mode[i]),
            .val(unit_val[i]), .hit(hits[i]), .pin_out(unit_pin_out[i]),
            .wd_req(wd_v[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= SRC_DIV_SLOW;
            ovf_q   <= 1'b0;
            flags_q <= '0;
        end else begin
            if (wr_ctrl) begin
                src_q <= src_sel_e'(wdata[2:1]);
                ovf_q <= (ovf_q & wdata[OVF_BIT]) | full_wrap;
            end else begin
                ovf_q <= ovf_q | full_wrap;
            end
            if (wr_flags) flags_q <= (flags_q & wdata[N_UNITS-1:0]) | hits;
            else          flags_q <= flags_q | hits;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_CTRL))
            rdata = DATA_W'({ovf_q, src_q, cnt_state == CNT_RUN});
        else if (addr == ADDR_W'(A_CNT_LO)) rdata = cnt_q[DATA_W-1:0];
        else if (addr == ADDR_W'(A_CNT_HI)) rdata = cnt_q[CNT_W-1:DATA_W];
        else if (addr == ADDR_W'(A_FLAGS))  rdata = DATA_W'(flags_q);
        for (int i = 0; i < N_UNITS; i++) begin
            if (addr == ADDR_W'(MODE_BASE + i))
                rdata = DATA_W'(unit_mode[i]);
            if (addr == ADDR_W'(VAL_BASE + 2 * i))
                rdata = unit_val[i][DATA_W-1:0];
            if (addr == ADDR_W'(VAL_BASE + 2 * i + 1))
                rdata = unit_val[i][CNT_W-1:DATA_W];
        end
    end

    assign unit_flag    = flags_q;
    assign ovf_flag     = ovf_q;
    assign wdog_rst_req = |wd_v;
endmodule

// File: rtl/pca_array_chk.sv
module pca_array_chk #(
    parameter int N_UNITS = 5,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [CNT_W-1:0]   cnt,
    input logic               ovf_flag,
    input logic               wdog_rst_req,
    input logic [N_UNITS-1:0] unit_flag,
    input logic [2:0]         mode0,
    input logic               pin0
);
    // R4
    ovf_from_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(cnt) == {CNT_W{1'b1}});

    // R2
    cnt_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1)));

    // R9
    wdog_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst_req |-> unit_flag[N_UNITS-1]);

    // R7
    toggle_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 == 3'd5 && $past(mode0) == 3'd5 && pin0 != $past(pin0))
            |-> unit_flag[0]);
endmodule

bind pca_array pca_array_chk #(.N_UNITS(N_UNITS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cnt(cnt_q),
    .ovf_flag(ovf_flag), .wdog_rst_req(wdog_rst_req), .unit_flag(unit_flag),
    .mode0(unit_mode[0]), .pin0(unit_pin_out[0])
);

// File: tb/pca_array_test.sv
module pca_array_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ovf_tick = 1'b0;
    logic       ext_cnt_pin = 1'b0;
    logic [4:0] unit_pin_in = '0;
    logic [4:0] unit_pin_out, unit_flag;
    logic       ovf_flag, wdog_rst_req;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pca_array uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ovf_tick(ovf_tick), .ext_cnt_pin(ext_cnt_pin),
        .unit_pin_in(unit_pin_in), .unit_pin_out(unit_pin_out),
        .unit_flag(unit_flag), .ovf_flag(ovf_flag), .wdog_rst_req(wdog_rst_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 5'(a); wdata = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        addr = 5'(a);
        #1 d = int'(rdata);
    endtask

    task automatic ld(input int v);
        wr(1, v & 8'hFF);
        wr(2, (v >> 8) & 8'hFF);
    endtask

    task automatic rd16(input int lo_a, output int v);
        int lo, hi;
        rd(lo_a, lo);
        rd(lo_a + 1, hi);
        v = (hi << 8) | lo;
    endtask

    task automatic pulse();
        @(negedge clk); ovf_tick = 1'b1;
        @(negedge clk); ovf_tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int v, c, exp_cap;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 26; a++) begin
            rd(a, v);
            chk($sformatf("R1 reg %0h", a), v, 0);
        end
        chk("R1 outputs", {unit_pin_out, unit_flag, ovf_flag, wdog_rst_req}, 0);

        // R2 load, step, hold
        ld(16'h1234);
        rd16(1, v); chk("R2 load", v, 16'h1234);
        wr(0, 8'h05);
        repeat (3) pulse();
        rd16(1, v); chk("R2 step", v, 16'h1237);
        wr(0, 8'h04);
        pulse();
        rd16(1, v); chk("R2 hold", v, 16'h1237);

        // R4 overflow
        wr(0, 8'h05);
        ld(16'hFFFF);
        pulse();
        rd16(1, v); chk("R4 wrap", v, 0);
        rd(0, v);   chk("R4 ctrl", v, 8'h0D);
        wr(0, 8'h05);
        chk("R4 clear", ovf_flag, 0);

        // R6 timer sweep over every channel
        for (int i = 0; i < 5; i++) begin
            c = 16'h0100 * (i + 1) + 16'h20 + i;
            wr(8 + i, 4);
            wr(16 + 2 * i, c & 8'hFF);
            wr(17 + 2 * i, c >> 8);
            ld(c - 2);
            pulse();
            chk($sformatf("R6 early ch%0d", i), unit_flag, 0);
            pulse();
            chk($sformatf("R6 match ch%0d", i), unit_flag, 1 << i);
            wr(3, 0);
            wr(8 + i, 0);
        end

        // R7 toggle
        wr(9, 5); wr(18, 8'h50); wr(19, 0);
        ld(16'h004F);
        pulse(); chk("R7 first toggle", unit_pin_out[1], 1);
        pulse(); chk("R7 no match", unit_pin_out[1], 1);
        ld(16'h004F);
        pulse(); chk("R7 second toggle", unit_pin_out[1], 0);
        wr(9, 0); wr(3, 0);

        // R8 pwm sweep of low byte
        wr(10, 6); wr(21, 8'h40);
        ld(16'h00FF);
        pulse();
        for (int lo = 0; lo < 256; lo++) begin
            wr(1, lo);
            chk($sformatf("R8 duty40 lo%0h", lo), unit_pin_out[2], (lo >= 8'h40) ? 1 : 0);
        end
        wr(21, 8'h80);
        wr(1, 8'h50); chk("R8 old duty held", unit_pin_out[2], 1);
        ld(16'h01FF);
        pulse();      chk("R8 new duty at wrap", unit_pin_out[2], 0);
        wr(1, 8'h50); chk("R8 new duty below", unit_pin_out[2], 0);
        wr(1, 8'h90); chk("R8 new duty above", unit_pin_out[2], 1);
        wr(10, 0);

        // R5 capture: every mode with both edge directions
        wr(0, 8'h04);
        for (int m = 1; m <= 3; m++) begin
            for (int e = 0; e < 2; e++) begin
                c = 16'h1000 + m * 16 + e;
                wr(11, 0); wr(22, 8'hAA); wr(23, 8'hAA);
                ld(c);
                unit_pin_in[3] = (e == 1);
                repeat (6) @(negedge clk);
                wr(11, m); wr(3, 0);
                unit_pin_in[3] = (e == 0);
                repeat (6) @(negedge clk);
                exp_cap = (m == 3) || (m == 1 && e == 0) || (m == 2 && e == 1);
                rd16(22, v);
                chk($sformatf("R5 val m%0d e%0d", m, e), v, exp_cap ? c : 16'hAAAA);
                chk($sformatf("R5 flag m%0d e%0d", m, e), unit_flag[3], exp_cap);
            end
        end
        wr(11, 0); unit_pin_in[3] = 1'b0; wr(3, 0);

        // R9 watchdog on last channel
        wr(0, 8'h05);
        wr(12, 7); wr(24, 8'h30); wr(25, 0);
        ld(16'h002F);
        pulse();
        chk("R9 request", wdog_rst_req, 1);
        chk("R9 flag", unit_flag[4], 1);
        @(negedge clk);
        chk("R9 single cycle", wdog_rst_req, 0);
        wr(3, 0);
        ld(16'h002F);
        wr(24, 8'h40);
        pulse();
        chk("R9 postponed", {wdog_rst_req, unit_flag[4]}, 0);
        wr(8, 7); wr(16, 8'h60); wr(17, 0);
        ld(16'h005F);
        pulse();
        chk("R9 not on ch0", {wdog_rst_req, unit_flag}, 0);
        wr(8, 0); wr(12, 0);

        // R10 set beats clear
        wr(8, 4); wr(16, 8'h70); wr(17, 0);
        ld(16'h006F);
        @(negedge clk);
        ovf_tick = 1'b1; wr_en = 1'b1; addr = 5'd3; wdata = 8'h00;
        @(negedge clk);
        ovf_tick = 1'b0; wr_en = 1'b0;
        chk("R10 set wins", unit_flag[0], 1);
        wr(3, 8'h1F); chk("R10 keep on 1", unit_flag[0], 1);
        wr(3, 8'h00); chk("R10 clear on 0", unit_flag[0], 0);
        wr(8, 0);

        // R3 count sources
        wr(0, 8'h02); ld(0); wr(0, 8'h03);
        repeat (40) @(negedge clk);
        wr(0, 8'h02);
        rd16(1, v); chk("R3 div2 range", (v >= 19 && v <= 22) ? 1 : 0, 1);
        wr(0, 8'h00); ld(0); wr(0, 8'h01);
        repeat (40) @(negedge clk);
        wr(0, 8'h00);
        rd16(1, v); chk("R3 div6 range", (v >= 5 && v <= 8) ? 1 : 0, 1);
        wr(0, 8'h06); ld(0); wr(0, 8'h07);
        for (int k = 0; k < 5; k++) begin
            ext_cnt_pin = 1'b1; repeat (3) @(negedge clk);
            ext_cnt_pin = 1'b0; repeat (3) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        wr(0, 8'h06);
        rd16(1, v); chk("R3 pin edges", v, 5);

        finish_run();
    end
endmodule